// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt

This block sits beside an address-translation pipeline and records what went wrong when a translation fails. The pipeline presents one pulse per fault type. Each pulse comes with the virtual address, the access direction, the table level, the physical address involved and the identity of the requesting master. Two enable registers select which fault types matter. The first enabled fault after an idle period is latched into read-only capture registers, and a level interrupt is raised to software.

Software reads the capture registers to diagnose the fault. It then writes a self-clearing clear bit, which drops the interrupt and opens the capture window again. While the interrupt is pending, later faults do not disturb the recorded information. Register access is a single-cycle write strobe with a combinational read port addressed by byte offset.

Top module: `fault_trap`

## Requirements
- R1: After reset, `irq` is 0 and every register offset reads 0.
- R2: Offset 0x124 holds the primary fault enables in bits 6:0 and reads them back. Offset 0x120 holds the auxiliary enables in bits 0, 1, 2, 3, 5 and 6. Bit 4 and bits 31:7 of 0x120 read as 0, and bit 12 of 0x120 always reads 0.
- R3: If a primary event bit and its enable are both 1 in cycle t, or an auxiliary event bit and its enable are both 1 in cycle t, and no interrupt is pending, then `irq` is 1 from cycle t+1 and the capture registers hold that event's data.
- R4: An event whose enable bit is 0 raises no interrupt and leaves every capture register unchanged.
- R5: Offset 0x13C returns the captured virtual address with bits 31:2 taken from `evt_va`, bit 1 the write flag (1 = write) and bit 0 the table level.
- R6: Offset 0x150 returns the captured arbiter ID in bits 9:7 and the port ID in bits 6:2; all other bits are 0.
- R7: Offset 0x140 returns the captured physical address unchanged.
- R8: Offset 0x134 returns the enabled primary event bits of the captured cycle in bits 6:0 and the enabled auxiliary event bits in bits 14:8 (auxiliary bit k at bit 8+k). All other bits are 0.
- R9: While `irq` is 1, later enabled faults change none of the capture registers unless the same cycle carries a clear.
- R10: A write to 0x120 with bit 12 set drops `irq` in the next cycle and zeroes offset 0x134. Offsets 0x13C, 0x140 and 0x150 keep their values. The same write also updates the auxiliary enables.
- R11: An enabled fault in the same cycle as a clear write is captured, and `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_main | input | 7 | Primary fault event pulses |
| evt_aux | input | 7 | Auxiliary fault event pulses (bit 4 unused) |
| evt_va | input | AW | Faulting virtual address |
| evt_pa | input | AW | Faulting physical address |
| evt_write | input | 1 | 1 for a write access |
| evt_level | input | 1 | Table level of the failing walk |
| evt_arb | input | 3 | Arbiter ID of the requester |
| evt_port | input | 5 | Port ID within the arbiter |
| irq | output | 1 | Level interrupt, pending fault |

## Verification
The assertions assume that the event data buses are valid whenever any event bit is high. They also assume that a clear is recognised only through a write strobe at offset 0x120, and that event pulses last exactly one cycle, with no back-pressure. The stimulus drives events and writes on the falling edge and holds them for one cycle. On most cycles it leaves events idle, so that clear, capture and hold windows all occur. It also forces the collisions of a fault with a clear and of a fault with a pending interrupt.

// File: rtl/fault_trap.sv
module fault_trap #(
  parameter int AW     = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [6:0]        evt_main,
  input  logic [6:0]        evt_aux,
  input  logic [AW-1:0]     evt_va,
  input  logic [AW-1:0]     evt_pa,
  input  logic              evt_write,
  input  logic              evt_level,
  input  logic [2:0]        evt_arb,
  input  logic [4:0]        evt_port,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'('h120);
  localparam logic [ADDR_W-1:0] OFS_MAIN = ADDR_W'('h124);
  localparam logic [ADDR_W-1:0] OFS_ST   = ADDR_W'('h134);
  localparam logic [ADDR_W-1:0] OFS_VA   = ADDR_W'('h13C);
  localparam logic [ADDR_W-1:0] OFS_PA   = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] OFS_ID   = ADDR_W'('h150);
  localparam logic [6:0]        AUX_MASK = 7'b1101111;
  localparam int                CLR_BIT  = 12;

  logic [6:0]    en_main, en_aux;
  logic          irq_q;
  logic [AW-1:0] cap_va, cap_pa;
  logic [2:0]    cap_arb;
  logic [4:0]    cap_port;
  logic [14:0]   cap_st;

  wire       wr_ctl   = wr_en && (addr == OFS_CTL);
  wire       wr_main  = wr_en && (addr == OFS_MAIN);
  wire       clr      = wr_ctl && wdata[CLR_BIT];
  wire [6:0] hit_main = evt_main & en_main;
  wire [6:0] hit_aux  = evt_aux & en_aux;
  wire       hit      = |{hit_main, hit_aux};
  wire       take     = hit && (!irq_q || clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_main <= '0;
      en_aux  <= '0;
    end else begin
      if (wr_main) en_main <= wdata[6:0];
      if (wr_ctl)  en_aux  <= wdata[6:0] & AUX_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      cap_va   <= '0;
      cap_pa   <= '0;
      cap_arb  <= '0;
      cap_port <= '0;
      cap_st   <= '0;
    end else if (take) begin
      irq_q    <= 1'b1;
      cap_va   <= {evt_va[AW-1:2], evt_write, evt_level};
      cap_pa   <= evt_pa;
      cap_arb  <= evt_arb;
      cap_port <= evt_port;
      cap_st   <= {hit_aux, 1'b0, hit_main};
    end else if (clr) begin
      irq_q  <= 1'b0;
      cap_st <= '0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTL:  rdata[6:0]  = en_aux;
      OFS_MAIN: rdata[6:0]  = en_main;
      OFS_ST:   rdata[14:0] = cap_st;
      OFS_VA:   rdata       = 32'(cap_va);
      OFS_PA:   rdata       = 32'(cap_pa);
      OFS_ID:   rdata[9:2]  = {cap_arb, cap_port};
      default:  rdata       = '0;
    endcase
  end
endmodule

// File: rtl/fault_trap_chk.sv
module fault_trap_chk #(
  parameter int AW     = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [6:0]        evt_main,
  input logic [6:0]        evt_aux,
  input logic [6:0]        en_main,
  input logic [6:0]        en_aux,
  input logic [AW-1:0]     cap_va,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] CTL = ADDR_W'('h120);
  wire fault = |(evt_main & en_main) || |(evt_aux & en_aux);
  wire clear = wr_en && (addr == CTL) && wdata[12];

  assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> irq);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !fault) |=> !irq);
  assert_hold_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear) |=> $stable(cap_va));
  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !fault) |=> !irq);
  assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTL) |-> !rdata[12]);
  assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && fault) |=> irq);
endmodule

bind fault_trap fault_trap_chk #(.AW(AW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .evt_main(evt_main), .evt_aux(evt_aux), .en_main(en_main),
  .en_aux(en_aux), .cap_va(cap_va), .irq(irq)
);

// File: tb/fault_trap_test.sv
`timescale 1ns/100ps
module fault_trap_test;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [6:0]  evt_main = 0, evt_aux = 0;
  logic [31:0] evt_va = 0, evt_pa = 0;
  logic        evt_write = 0, evt_level = 0, irq;
  logic [2:0]  evt_arb = 0;
  logic [4:0]  evt_port = 0;

  int compared = 0, mismatched = 0;
  logic [6:0]  m_en_main = 0, m_en_aux = 0;
  logic        m_irq = 0;
  logic [31:0] m_va = 0, m_pa = 0, m_id = 0, m_st = 0;

  always #4 clk = ~clk;

  fault_trap uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_main(evt_main), .evt_aux(evt_aux),
    .evt_va(evt_va), .evt_pa(evt_pa), .evt_write(evt_write),
    .evt_level(evt_level), .evt_arb(evt_arb), .evt_port(evt_port), .irq(irq));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, string req, logic [31:0] exp);
    addr = a; #0.5;
    check(req, rdata, exp);
  endtask

  task automatic check_all(string tag);
    check({tag, " R3 irq"}, 32'(irq), 32'(m_irq));
    rd(12'h134, {tag, " R8 status"}, m_st);
    rd(12'h13C, {tag, " R5 va"}, m_va);
    rd(12'h140, {tag, " R7 pa"}, m_pa);
    rd(12'h150, {tag, " R6 id"}, m_id);
    rd(12'h120, {tag, " R2 aux en"}, {25'b0, m_en_aux});
    rd(12'h124, {tag, " R2 main en"}, {25'b0, m_en_main});
  endtask

  function automatic logic [31:0] mk_va(logic [31:0] v, logic w, logic l);
    return {v[31:2], w, l};
  endfunction

  task automatic step(logic [6:0] mn, logic [6:0] ax, logic w, logic [11:0] a,
                      logic [31:0] d, string tag);
    logic [6:0] hm, ha;
    logic clr, take;
    @(negedge clk);
    evt_main = mn; evt_aux = ax; wr_en = w; addr = a; wdata = d;
    evt_va = $urandom; evt_pa = $urandom; evt_write = 1'($urandom);
    evt_level = 1'($urandom); evt_arb = 3'($urandom); evt_port = 5'($urandom);
    hm = mn & m_en_main; ha = ax & m_en_aux;
    clr = w && a == 12'h120 && d[12];
    take = ((hm | ha) != 0) && (!m_irq || clr);
    @(posedge clk); #1;
    if (take) begin
      m_irq = 1; m_va = mk_va(evt_va, evt_write, evt_level); m_pa = evt_pa;
      m_id = {22'b0, evt_arb, evt_port, 2'b0}; m_st = {17'b0, ha, 1'b0, hm};
    end else if (clr) begin
      m_irq = 0; m_st = 0;
    end
    if (w && a == 12'h124) m_en_main = d[6:0];
    if (w && a == 12'h120) m_en_aux = d[6:0] & 7'h6F;
    @(negedge clk);
    wr_en = 0; evt_main = 0; evt_aux = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_all("R1 reset");
    rd(12'h000, "R1 unmapped", 0);
    step(7'h7F, 7'h7F, 0, 0, 0, "R4 all disabled");
    step(0, 0, 1, 12'h124, 32'hFFFF_FF85, "R2 main write");
    step(0, 0, 1, 12'h120, 32'hFFFF_EFFF, "R2 aux write no clr");
    rd(12'h120, "R2 bit12 reads 0", 32'h6F);
    step(0, 0, 1, 12'h120, 32'h0000_0022, "R2 aux narrow");
    step(7'h02, 7'h01, 0, 0, 0, "R4 unenabled types");
    step(7'h04, 7'h02, 0, 0, 0, "R3 capture");
    step(7'h01, 7'h20, 0, 0, 0, "R9 hold first");
    step(0, 0, 1, 12'h120, 32'h0000_1022, "R10 clear");
    step(7'h81 & 7'h7F, 0, 0, 0, 0, "R3 second capture");
    step(7'h04, 0, 1, 12'h120, 32'h0000_1022, "R11 clear with fault");
    step(0, 0, 1, 12'h120, 32'h0000_1000, "R10 clear disables aux");
    step(0, 7'h22, 0, 0, 0, "R4 aux now disabled");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      logic [6:0] mn, ax;
      r = 4'($urandom);
      mn = (r < 5) ? 7'($urandom) : 7'h0;
      ax = (r == 4 || r == 6) ? 7'($urandom) : 7'h0;
      case (r)
        7, 8:   step(mn, ax, 1, 12'h120, {19'b0, 1'b1, 5'b0, 7'($urandom)}, "R10 rnd clear");
        9:      step(mn, ax, 1, 12'h124, $urandom, "R2 rnd main");
        10:     step(mn, ax, 1, 12'h120, $urandom, "R2 rnd aux");
        default: step(mn, ax, 0, 0, 0, "R9 rnd event");
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule